// File: doc/BRIEF.md
# Carry-Less Multiply Unit

This unit multiplies two XLEN-bit operands as polynomials over GF(2). Partial products are combined with XOR, so no carry ever moves from one column into the next. The full product is 2·XLEN bits wide. A 2-bit function code picks which XLEN-bit window of that product reaches the output:

- the lower half,
- the upper half, or
- the window that starts one bit below the middle.

The third window is the bit-reversed form of the product. It is the one used to speed up CRC computation. The two half windows are what a GHASH step needs.

A caller presents both operands, the function code and a valid strobe on the same clock. The result and its valid flag appear one clock later. The result holds its value until the next accepted operation. XLEN is a parameter, either 32 or 64.

Top module: `clmul_unit`

## Requirements
- R1: With function code 2'b00 the result is bits XLEN-1..0 of the carry-less product of `in_a` and `in_b`. That product is the XOR of `in_a` shifted left by i, taken over every set bit i of `in_b`.
- R2: With function code 2'b01 the result is product bits 2·XLEN-1..XLEN. Bit XLEN-1 of this result is therefore always 0.
- R3: With function code 2'b10 the result is product bits 2·XLEN-2..XLEN-1. For example, when `in_b` equals 1 the result equals `in_a` shifted right by XLEN-1.
- R4: Function code 2'b11 yields an all-zero result.
- R5: `out_valid` is high in exactly the cycle that follows a cycle with `in_valid` high. The result of that operation is on `out_result` in the same cycle.
- R6: While `rst_n` is low at a rising edge, `out_valid` is low after that edge, whatever `in_valid` is.
- R7: In a cycle with `in_valid` low, `out_result` keeps the value of the last accepted operation.
- R8: The function code 2'b10 result equals the following: reverse the bits of both operands, take the code 2'b00 result of those, then reverse the bits of that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| in_func | input | 2 | Window select: 00 low, 01 high, 10 reversed, 11 zero |
| in_a | input | XLEN | First operand |
| in_b | input | XLEN | Second operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | XLEN | Selected product window |

## Verification
Every result is due exactly one rising edge after the edge that captures `in_valid`. The bench drives operands on falling edges and reads `out_valid` and `out_result` on the next falling edge, which is the middle of the cycle in which the registered result is visible. For the hold and reset checks, the bench inserts one more idle or reset cycle. It then samples on the falling edge after that, so the single register stage is always counted before any comparison.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  typedef enum logic [1:0] {
    FN_LOW  = 2'b00,
    FN_HIGH = 2'b01,
    FN_REV  = 2'b10,
    FN_NONE = 2'b11
  } clmul_fn_e;

endpackage

// File: rtl/clmul_array.sv
module clmul_array #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic [2*XLEN-1:0] prod
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0] a_wide;
  logic [PW-1:0] acc [XLEN+1];

  assign a_wide = {{XLEN{1'b0}}, op_a};
  assign acc[0] = '0;

  // One XOR stage per multiplier bit; no carries between columns.
  for (genvar i = 0; i < XLEN; i++) begin : g_row
    logic [PW-1:0] part;
    assign part       = op_b[i] ? (a_wide << i) : '0;
    assign acc[i + 1] = acc[i] ^ part;
  end

  assign prod = acc[XLEN];
endmodule

// File: rtl/clmul_window.sv
module clmul_window
  import clmul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2*XLEN-1:0] prod,
  input  logic [1:0]        func,
  output logic [XLEN-1:0]   win
);
  function automatic logic [XLEN-1:0] pick(input logic [2*XLEN-1:0] p,
                                            input logic [1:0] f);
    case (clmul_fn_e'(f))
      FN_LOW:  pick = p[XLEN-1:0];
      FN_HIGH: pick = p[2*XLEN-1:XLEN];
      FN_REV:  pick = p[2*XLEN-2:XLEN-1];
      default: pick = '0;
    endcase
  endfunction

  assign win = pick(prod, func);
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_func,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   prod_full;
  logic [XLEN-1:0] win_next;
  logic            capture_en;

  assign capture_en = in_valid;

  clmul_array #(.XLEN(XLEN)) u_array (
    .op_a (in_a),
    .op_b (in_b),
    .prod (prod_full)
  );

  clmul_window #(.XLEN(XLEN)) u_window (
    .prod (prod_full),
    .func (in_func),
    .win  (win_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= capture_en;
  end

  always_ff @(posedge clk) begin
    if (capture_en) out_result <= win_next;
  end
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk
  import clmul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [1:0]      in_func,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result
);
  AST_LOW_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_func == FN_LOW) |=> out_result[0] == ($past(in_a[0]) & $past(in_b[0]))); // R1
  AST_HIGH_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_func == FN_HIGH) |=> out_result[XLEN-1] == 1'b0); // R2
  AST_REV_UNIT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_func == FN_REV && in_b == XLEN'(1)) |=> out_result == XLEN'($past(in_a[XLEN-1]))); // R3
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_func == FN_NONE) |=> out_result == '0); // R4
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !out_valid); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result)); // R7
endmodule

bind clmul_unit clmul_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_func    (in_func),
  .in_a       (in_a),
  .in_b       (in_b),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/clmul_unit_tb.sv
module clmul_unit_tb;
  localparam int XLEN       = 32;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;

  // {func, a, b, expected}
  localparam logic [97:0] VEC [NVEC] = '{
    {2'b00, 32'h0000_0003, 32'h0000_0003, 32'h0000_0005},
    {2'b01, 32'h0000_0003, 32'h0000_0003, 32'h0000_0000},
    {2'b00, 32'h8000_0000, 32'h0000_0002, 32'h0000_0000},
    {2'b01, 32'h8000_0000, 32'h0000_0002, 32'h0000_0001},
    {2'b10, 32'h8000_0000, 32'h0000_0002, 32'h0000_0002},
    {2'b10, 32'h0000_0001, 32'h8000_0000, 32'h0000_0001},
    {2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {2'b00, 32'h0000_00FF, 32'h0000_00FF, 32'h0000_5555},
    {2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555},
    {2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hAAAA_AAAA}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      in_func = 2'b00;
  logic [XLEN-1:0] in_a = '0;
  logic [XLEN-1:0] in_b = '0;
  logic            out_valid;
  logic [XLEN-1:0] out_result;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clmul_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [2*XLEN-1:0] serial_prod(input logic [XLEN-1:0] a,
                                                    input logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] p = '0;
    for (int i = 0; i < XLEN; i++)
      for (int j = 0; j < XLEN; j++)
        if (a[j] && b[i]) p[i + j] = ~p[i + j];
    return p;
  endfunction

  function automatic logic [XLEN-1:0] flip(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] expect_win(input logic [1:0] f,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] p = serial_prod(a, b);
    logic [XLEN-1:0] r = '0;
    case (f)
      2'b00: r = p[XLEN-1:0];
      2'b01: r = p[2*XLEN-1:XLEN];
      2'b10: for (int k = 0; k < XLEN; k++) r[k] = p[XLEN - 1 + k];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] f, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_func = f; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] held;
    logic [XLEN-1:0] ra;
    logic [XLEN-1:0] rb;
    logic [1:0]      rf;

    // R6: reset state, even with in_valid high
    @(negedge clk); in_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 reset valid", XLEN'(out_valid), '0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 idle valid", XLEN'(out_valid), '0);

    // Table of vectors (R1 R2 R3 R4)
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][97:96], VEC[v][95:64], VEC[v][63:32]);
      check("R5 valid after op", XLEN'(out_valid), XLEN'(1));
      case (VEC[v][97:96])
        2'b00: check("R1 table low", out_result, VEC[v][31:0]);
        2'b01: check("R2 table high", out_result, VEC[v][31:0]);
        2'b10: check("R3 table rev", out_result, VEC[v][31:0]);
        default: check("R4 table none", out_result, VEC[v][31:0]);
      endcase
    end

    // Random operands against serial reference
    for (int n = 0; n < 60; n++) begin
      ra = $urandom; rb = $urandom; rf = 2'(n % 4);
      run_op(rf, ra, rb);
      case (rf)
        2'b00: check("R1 random low", out_result, expect_win(rf, ra, rb));
        2'b01: check("R2 random high", out_result, expect_win(rf, ra, rb));
        2'b10: begin
          check("R3 random rev", out_result, expect_win(rf, ra, rb));
          check("R8 rev identity", out_result,
                flip(expect_win(2'b00, flip(ra), flip(rb))));
        end
        default: check("R4 random none", out_result, '0);
      endcase
    end

    // Single-bit operands at the edges
    run_op(2'b10, 32'h8000_0000, 32'h8000_0000);
    check("R3 single msb rev", out_result, 32'h8000_0000);
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000);
    check("R2 single msb high", out_result, 32'h4000_0000);
    run_op(2'b00, 32'h0000_0001, 32'h0000_0001);
    check("R1 single lsb low", out_result, 32'h0000_0001);

    // R7: hold while idle, inputs changing
    run_op(2'b00, 32'h0000_0007, 32'h0000_0003);
    held = out_result;
    check("R1 hold setup", held, 32'h0000_0009);
    @(negedge clk);
    in_func = 2'b01; in_a = 32'hFFFF_FFFF; in_b = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R7 hold value", out_result, held);
    check("R5 idle after hold", XLEN'(out_valid), '0);

    // R6: reset mid-run
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R6 mid reset", XLEN'(out_valid), '0);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule